// File: doc/BRIEF.md
# Status Byte and Service Request Logic

This block assembles an 8-bit instrument status byte from five summary flags that other logic supplies. The flags are a general operation flag, the standard event summary, output-queue-not-empty, error-queue-not-empty and the ready event summary. A host-written enable mask selects which of these flags may raise a request for service. Bit 6 of the byte is special. It carries a live master summary, which is the OR of every enabled flag. It also carries a latched request flag, and that flag is what drives the service request line of the instrument bus.

The byte can be read two ways. A serial poll read returns the latched request flag in bit 6, and the poll itself clears that latch. A status query read returns the live master summary in bit 6. The master summary is read-only and drops only when all enabled causes have gone away. All other bits are the same on both read paths. When the host talks through the serial port rather than the instrument bus, no request is latched and the service request line stays low, so the host must poll instead.

Top module: `svc_status_top`

## Requirements
- R1: After reset the enable mask is 0, the request latch is clear, `srq_o` is 0 and bit 6 of both read bytes is 0.
- R2: On both read bytes, bit 7 follows `oper_i`, bit 5 follows `esb_i`, bit 4 follows `mav_i`, bit 2 follows `err_i` and bit 0 follows `rsr_i`, within the same cycle. Bits 3 and 1 always read 0.
- R3: A cycle with `en_wr_i` high loads `en_wdata_i` into the enable mask. The new mask takes effect from the following cycle.
- R4: Bit 6 of the query byte (the master summary) is the OR, over bit positions 7, 5, 4, 2 and 0, of the status bit ANDed with the enable bit at the same position. Enable bit 6 has no effect.
- R5: The master summary is level-sensitive. It falls in the same cycle that the last enabled cause clears.
- R6: On a clock edge where the master summary is high, was low at the previous edge, and `bus_sel_i` is 1, the request latch is set. `srq_o` is the latch value gated by `bus_sel_i`. A master summary that stays high does not set the latch again.
- R7: Bit 6 of the poll byte shows the request latch. A cycle with `poll_i` high clears the latch at the end of that cycle, unless R10 applies.
- R8: Once set, the request latch stays set until a poll, even after the master summary falls.
- R9: While `bus_sel_i` is 0, a rising master summary does not set the request latch and `srq_o` is 0.
- R10: When a rising master summary and a poll occur in the same cycle, the latch ends up set.
- R11: With an enable mask of 0x14, only `mav_i` or `err_i` can raise the master summary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| oper_i | input | 1 | Operation flag (status bit 7) |
| esb_i | input | 1 | Standard event summary (bit 5) |
| mav_i | input | 1 | Output queue holds at least one reply (bit 4) |
| err_i | input | 1 | Error queue holds at least one entry (bit 2) |
| rsr_i | input | 1 | Ready event summary (bit 0) |
| en_wr_i | input | 1 | Enable mask write strobe |
| en_wdata_i | input | 8 | Enable mask write data |
| poll_i | input | 1 | Serial poll read in progress; clears the request latch |
| bus_sel_i | input | 1 | 1 when the instrument bus is the active host port, 0 for the serial port |
| poll_byte_o | output | 8 | Status byte as seen by a serial poll (bit 6 = request latch) |
| query_byte_o | output | 8 | Status byte as seen by a status query (bit 6 = master summary) |
| srq_o | output | 1 | Service request line |

## Verification
The bench builds the block with its default 8-bit byte, so the bit-6 exclusion and the fixed bit positions are exercised exactly as the host sees them. It walks the enable mask through three values: bit 6 alone, 0x14 and all ones. These expose the masking, the ignored enable bit, edge-only latching, a poll colliding with a new request, and the serial-port path where the request line must stay low.

// File: rtl/svc_pkg.sv
package svc_pkg;
  localparam int STB_W    = 8;
  localparam int OPER_POS = 7;
  localparam int SUM_POS  = 6;
  localparam int ESB_POS  = 5;
  localparam int MAV_POS  = 4;
  localparam int ERR_POS  = 2;
  localparam int RSR_POS  = 0;
endpackage

// File: rtl/svc_rst_sync.sv
module svc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/svc_enable_reg.sv
module svc_enable_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] en_o
);
  logic [W-1:0] en_q;
  logic [W-1:0] en_d;

  always_comb begin
    en_d = en_q;
    if (wr_i) en_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  assign en_o = en_q;

  // R3
  en_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (en_o == $past(wdata_i)));
endmodule

// File: rtl/svc_summary.sv
module svc_summary #(
  parameter int W       = 8,
  parameter int SUM_POS = 6
) (
  input  logic [W-1:0] stat_i,
  input  logic [W-1:0] en_i,
  output logic         mss_o
);
  localparam logic [W-1:0] KEEP = ~(W'(1) << SUM_POS);

  logic [W-1:0] hits;

  always_comb begin
    hits  = stat_i & en_i & KEEP;
    mss_o = |hits;
  end
endmodule

// File: rtl/svc_request.sv
module svc_request (
  input  logic clk,
  input  logic rst_n,
  input  logic mss_i,
  input  logic bus_i,
  input  logic poll_i,
  output logic rqs_o
);
  logic rqs_q, rqs_d;
  logic mss_q, mss_d;
  logic rise;

  always_comb begin
    rise  = mss_i & ~mss_q;
    mss_d = mss_i;
    rqs_d = rqs_q;
    if (rise && bus_i) rqs_d = 1'b1;
    else if (poll_i)   rqs_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rqs_q <= 1'b0;
      mss_q <= 1'b0;
    end else begin
      rqs_q <= rqs_d;
      mss_q <= mss_d;
    end
  end

  assign rqs_o = rqs_q;

  // R6
  rqs_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mss_i && !mss_q && bus_i) |=> rqs_o);
  // R7
  poll_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_i && !(mss_i && !mss_q && bus_i)) |=> !rqs_o);
  // R8
  rqs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rqs_o && !poll_i) |=> rqs_o);
  // R9
  serial_noset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_i && !rqs_o) |=> !rqs_o);
endmodule

// File: rtl/svc_status_top.sv
module svc_status_top
  import svc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             oper_i,
  input  logic             esb_i,
  input  logic             mav_i,
  input  logic             err_i,
  input  logic             rsr_i,
  input  logic             en_wr_i,
  input  logic [STB_W-1:0] en_wdata_i,
  input  logic             poll_i,
  input  logic             bus_sel_i,
  output logic [STB_W-1:0] poll_byte_o,
  output logic [STB_W-1:0] query_byte_o,
  output logic             srq_o
);
  logic             rst_i_n;
  logic [STB_W-1:0] stat;
  logic [STB_W-1:0] en_mask;
  logic             mss;
  logic             rqs;

  svc_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_i_n)
  );

  always_comb begin
    stat           = '0;
    stat[OPER_POS] = oper_i;
    stat[ESB_POS]  = esb_i;
    stat[MAV_POS]  = mav_i;
    stat[ERR_POS]  = err_i;
    stat[RSR_POS]  = rsr_i;
  end

  svc_enable_reg #(.W(STB_W)) u_en (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .wr_i   (en_wr_i),
    .wdata_i(en_wdata_i),
    .en_o   (en_mask)
  );

  svc_summary #(.W(STB_W), .SUM_POS(SUM_POS)) u_sum (
    .stat_i(stat),
    .en_i  (en_mask),
    .mss_o (mss)
  );

  svc_request u_req (
    .clk   (clk),
    .rst_n (rst_i_n),
    .mss_i (mss),
    .bus_i (bus_sel_i),
    .poll_i(poll_i),
    .rqs_o (rqs)
  );

  always_comb begin
    query_byte_o          = stat;
    query_byte_o[SUM_POS] = mss;
    poll_byte_o           = stat;
    poll_byte_o[SUM_POS]  = rqs;
    srq_o                 = rqs & bus_sel_i;
  end

  // R4
  mss_cause_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (((stat[OPER_POS] & en_mask[OPER_POS]) | (stat[ESB_POS] & en_mask[ESB_POS]) |
      (stat[MAV_POS] & en_mask[MAV_POS]) | (stat[ERR_POS] & en_mask[ERR_POS]) |
      (stat[RSR_POS] & en_mask[RSR_POS])) == 1'b0) |-> !query_byte_o[SUM_POS]);
endmodule

// File: tb/sim_svc_status_top.sv
module sim_svc_status_top;
  localparam int CLK_P = 10;

  typedef struct {
    string      tag;
    logic [7:0] pb;
    logic [7:0] qb;
    logic       srq;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       oper_i, esb_i, mav_i, err_i, rsr_i;
  logic       en_wr_i, poll_i, bus_sel_i;
  logic [7:0] en_wdata_i;
  logic [7:0] poll_byte_o, query_byte_o;
  logic       srq_o;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;

  logic [7:0] en_m;
  logic       rqs_m, mssq_m;

  always #(CLK_P/2) clk = ~clk;

  svc_status_top u0 (
    .clk(clk), .rst_n(rst_n), .oper_i(oper_i), .esb_i(esb_i), .mav_i(mav_i),
    .err_i(err_i), .rsr_i(rsr_i), .en_wr_i(en_wr_i), .en_wdata_i(en_wdata_i),
    .poll_i(poll_i), .bus_sel_i(bus_sel_i), .poll_byte_o(poll_byte_o),
    .query_byte_o(query_byte_o), .srq_o(srq_o)
  );

  task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // st = {oper, esb, mav, err, rsr}
  task automatic step(input logic [4:0] st, input logic wr, input logic [7:0] wd,
                      input logic poll, input logic bus, input string tag);
    logic [7:0] stat;
    logic       mss;
    exp_t       e;
    @(negedge clk);
    {oper_i, esb_i, mav_i, err_i, rsr_i} = st;
    en_wr_i = wr; en_wdata_i = wd; poll_i = poll; bus_sel_i = bus;
    stat = {st[4], 1'b0, st[3], st[2], 1'b0, st[1], 1'b0, st[0]};
    mss  = |(stat & en_m & 8'hBF);
    e.tag = tag;
    e.qb  = stat | {1'b0, mss, 6'b0};
    e.pb  = stat | {1'b0, rqs_m, 6'b0};
    e.srq = rqs_m & bus;
    exp_q.push_back(e);
    if (mss && !mssq_m && bus) rqs_m = 1'b1;
    else if (poll)             rqs_m = 1'b0;
    mssq_m = mss;
    if (wr) en_m = wd;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check8({e.tag, " query"}, query_byte_o, e.qb);
        check8({e.tag, " poll"}, poll_byte_o, e.pb);
        check8({e.tag, " srq"}, {7'b0, srq_o}, {7'b0, e.srq});
      end
    end
  end

  initial begin
    #(CLK_P * 5000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    en_m = '0; rqs_m = 1'b0; mssq_m = 1'b0;
    rst_n = 1'b0;
    {oper_i, esb_i, mav_i, err_i, rsr_i} = '1;
    en_wr_i = 1'b0; en_wdata_i = '0; poll_i = 1'b0; bus_sel_i = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state, all status inputs high but mask zero
    check8("R1 query", query_byte_o, 8'hB5);
    check8("R1 poll", poll_byte_o, 8'hB5);
    check8("R1 srq", {7'b0, srq_o}, 8'h00);
    {oper_i, esb_i, mav_i, err_i, rsr_i} = '0;
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);

    step(5'b00000, 0, 8'h00, 0, 1, "R2 idle");
    step(5'b11111, 0, 8'h00, 0, 1, "R2 all flags");
    step(5'b10101, 0, 8'h00, 0, 1, "R2 oper/mav/rsr");
    step(5'b11111, 1, 8'h40, 0, 1, "R3 write bit6 mask");
    step(5'b11111, 0, 8'h00, 0, 1, "R4 bit6 enable ignored");
    step(5'b11111, 0, 8'h00, 1, 1, "R4 no latch from bit6");
    step(5'b00000, 1, 8'h14, 0, 1, "R11 write 0x14");
    step(5'b11001, 0, 8'h00, 0, 1, "R11 oper/esb/rsr masked");
    step(5'b00100, 0, 8'h00, 0, 1, "R11 mav raises summary");
    step(5'b00000, 0, 8'h00, 0, 1, "R6 latch set, R5 summary drops");
    step(5'b00000, 0, 8'h00, 0, 1, "R8 latch holds");
    step(5'b00000, 0, 8'h00, 1, 1, "R7 poll sees latch");
    step(5'b00000, 0, 8'h00, 0, 1, "R7 latch cleared");
    step(5'b00010, 0, 8'h00, 0, 1, "R11 err raises summary");
    step(5'b00010, 0, 8'h00, 1, 1, "R7 poll while cause held");
    step(5'b00010, 0, 8'h00, 0, 1, "R6 no relatch on steady summary");
    step(5'b00000, 0, 8'h00, 0, 1, "R5 summary falls");
    step(5'b00010, 0, 8'h00, 1, 1, "R10 rise with poll");
    step(5'b00010, 0, 8'h00, 0, 1, "R10 set wins");
    step(5'b00000, 0, 8'h00, 1, 1, "R7 clear");
    step(5'b00000, 0, 8'h00, 0, 0, "R9 serial idle");
    step(5'b00110, 0, 8'h00, 0, 0, "R9 rise on serial port");
    step(5'b00110, 0, 8'h00, 0, 0, "R9 no latch");
    step(5'b00110, 0, 8'h00, 0, 1, "R9 back on bus no latch");
    step(5'b10000, 1, 8'hFF, 0, 1, "R3 write all ones");
    step(5'b10000, 0, 8'h00, 0, 1, "R4 oper enabled");
    step(5'b10000, 0, 8'h00, 0, 1, "R6 latched from oper");
    step(5'b00001, 0, 8'h00, 0, 1, "R5 rsr keeps summary");
    step(5'b00000, 0, 8'h00, 1, 1, "R7 final poll");
    step(5'b00000, 0, 8'h00, 0, 1, "R7 final clear");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule